// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is a register-mapped controller for a small array of one-time-programmable fuse words. The array is held in ordinary flops. Each fuse word also has a shadow register, which software can read and can overwrite to replace a value without burning fuses. Software picks a word through an address field, which is the bank number times eight plus the word within the bank. It then starts one of two operations. A sense copies the fuse word into a result register. A program ORs a 32-bit value into the fuse word, so fuse bits can only go from 0 to 1.

Programming needs a 16-bit key in the upper half of the control register, and the key is wiped when each program operation ends. Both operations raise a busy flag for a length set by a timing register. That length is counted in clocks and contains a lead-in relax period and a trailing relax period, each of (relax+1) clocks. Misuse sets an error flag. The error flag stays set until software writes 1 to bit 9 of the clear alias of the control register. The bus is a single-cycle write port with a combinational read data path.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control register (0x000) reads 0, the timing register (0x010) reads 0x0006100A, the sense result (0x040) reads 0, and every shadow word reads 0.
- R2: The control register holds the unlock field in bits 31:16, the error flag in bit 9, the busy flag in bit 8 and the word address in bits 6:0. All other bits read 0. A direct write at 0x000 loads only the unlock and address fields.
- R3: A write at the set alias (0x004) ORs its unlock and address bits into the register, and a write at the clear alias (0x008) clears the matching bits. The error flag is sticky: only a 1 in bit 9 written at the clear alias clears it.
- R4: The timing register holds the read-strobe count in bits 21:16, the relax count in bits 15:12 and the program-strobe count in bits 11:0. Bits 31:22 read 0.
- R5: Busy stays high for exactly max(S+1, 2·R+3) clocks, where R is the relax count and S is the strobe count that belongs to the operation (read strobe for a sense, program strobe for a program), both taken when the operation starts.
- R6: A write at the data register (0x020) starts a program only when the unlock field equals 0x3E77, busy is low and the address is below the word count. When busy falls, the fuse word equals its old value OR the data, and that word's shadow holds the new fuse value.
- R7: The unlock field reads 0 after a program operation completes.
- R8: Writing 1 in bit 0 at the sense-control register (0x030) starts a sense. When busy falls, the sense result holds the addressed fuse word. A write with bit 0 clear starts nothing.
- R9: Any of the following sets the error flag and starts no operation: a data write without the key, a data write while busy, a sense start while busy, or an address at or above the word count.
- R10: A write at shadow word n (0x200 + 4·n) changes only that shadow. The fuse word, as later seen by a sense, is unchanged.
- R11: Word address = bank·8 + word. Bank 1 word 3 is address 11, and its shadow sits at 0x22C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_BITS (10) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Program data is applied in two patterns to the same word: first a low nibble group, then a disjoint pattern. This distinguishes an OR into the fuse from a plain overwrite, and the shadow value after a prior override shows whether the shadow is refreshed from the fuse or merged with the old shadow. Busy length is measured for both long and short strobe counts against a nonzero relax count, which separates the strobe-dominated case from the relax-dominated floor. Misuse patterns (no key, a wrong key, starting while busy, an address past the array) are each followed by a sense of the word, which shows that no fuse changed.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned KEY_W      = 16;
  localparam int unsigned WADDR_W    = 7;
  localparam int unsigned RDSTB_W    = 6;
  localparam int unsigned RELAX_W    = 4;
  localparam int unsigned PGSTB_W    = 12;
  localparam int unsigned BANK_WORDS = 8;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam int unsigned CTRL_ERR_BIT  = 9;
  localparam int unsigned CTRL_BUSY_BIT = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LEAD   = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_TAIL   = 2'd3
  } seq_state_e;

  typedef enum logic {
    OP_SENSE = 1'b0,
    OP_PROG  = 1'b1
  } op_kind_e;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned RLX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] strobe_cnt,
  input  logic [RLX_W-1:0] relax_cnt,
  output logic             busy,
  output logic             done
);
  localparam int unsigned W1 = CNT_W + 1;
  localparam int unsigned W2 = CNT_W + 2;

  seq_state_e       state_q, state_d;
  logic [W1-1:0]    cnt_q, cnt_d;
  logic [RLX_W-1:0] rlx_q, rlx_d;
  logic [W1-1:0]    mid_q, mid_d;

  logic [W1-1:0] lead2;
  logic [W1-1:0] strobe_w;
  logic [W1-1:0] mid_m1;

  // Two relax periods are folded into the strobe count.
  assign lead2    = (W1'(relax_cnt) + W1'(1)) << 1;
  assign strobe_w = W1'(strobe_cnt);
  assign mid_m1   = (strobe_w >= lead2) ? (strobe_w - lead2) : '0;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rlx_d   = rlx_q;
    mid_d   = mid_q;
    done    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_LEAD;
          cnt_d   = W1'(relax_cnt);
          rlx_d   = relax_cnt;
          mid_d   = mid_m1;
        end
      end
      SEQ_LEAD: begin
        if (cnt_q == '0) begin
          state_d = SEQ_STROBE;
          cnt_d   = mid_q;
        end else begin
          cnt_d = cnt_q - W1'(1);
        end
      end
      SEQ_STROBE: begin
        if (cnt_q == '0) begin
          state_d = SEQ_TAIL;
          cnt_d   = W1'(rlx_q);
        end else begin
          cnt_d = cnt_q - W1'(1);
        end
      end
      SEQ_TAIL: begin
        if (cnt_q == '0) begin
          state_d = SEQ_IDLE;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q - W1'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      rlx_q   <= '0;
      mid_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rlx_q   <= rlx_d;
      mid_q   <= mid_d;
    end
  end

  assign busy = (state_q != SEQ_IDLE);

  // Checking aid: an independent busy-length count against the closed form.
  logic [W2-1:0] span_q;
  logic [W2-1:0] expect_q;
  logic [W2-1:0] expect_calc;
  assign expect_calc = (W2'(strobe_cnt) + W2'(1) > W2'(2) * W2'(relax_cnt) + W2'(3))
                     ? W2'(strobe_cnt) + W2'(1)
                     : W2'(2) * W2'(relax_cnt) + W2'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q   <= '0;
      expect_q <= '0;
    end else if (start && !busy) begin
      span_q   <= '0;
      expect_q <= expect_calc;
    end else if (busy) begin
      span_q <= span_q + W2'(1);
    end
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (span_q + W2'(1) == expect_q));

  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  p_done_drops_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [IDX_W-1:0]  prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              sh_wr,
  input  logic [IDX_W-1:0]  sh_idx,
  input  logic [DATA_W-1:0] sh_wdata,
  input  logic [IDX_W-1:0]  fuse_idx,
  output logic [DATA_W-1:0] fuse_rdata,
  output logic [DATA_W-1:0] sh_rdata
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] fuse_q, fuse_d;
  logic [NUM_WORDS-1:0][DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    fuse_d = fuse_q;
    sh_d   = sh_q;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (sh_wr && (sh_idx == IDX_W'(w))) begin
        sh_d[w] = sh_wdata;
      end
      // A completing program wins over a same-cycle override.
      if (prog_en && (prog_idx == IDX_W'(w))) begin
        fuse_d[w] = fuse_q[w] | prog_data;
        sh_d[w]   = fuse_q[w] | prog_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuse_q <= '0;
      sh_q   <= '0;
    end else begin
      fuse_q <= fuse_d;
      sh_q   <= sh_d;
    end
  end

  assign fuse_rdata = fuse_q[fuse_idx];
  assign sh_rdata   = sh_q[sh_idx];

  p_prog_sets_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((fuse_q[$past(prog_idx)] & $past(prog_data)) == $past(prog_data)));

  p_override_keeps_fuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && !prog_en) |=> $stable(fuse_q));

  p_fuse_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((fuse_q[$past(prog_idx)] & $past(fuse_q[prog_idx])) == $past(fuse_q[prog_idx])));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 16,
  parameter int unsigned ADDR_BITS   = 10,
  parameter int unsigned RDSTB_RST   = 6,
  parameter int unsigned RELAX_RST   = 1,
  parameter int unsigned PGSTB_RST   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_BITS-1:0] bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata
);
  localparam int unsigned IDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned SIDX_W = ADDR_BITS - 3;
  localparam logic [ADDR_BITS-1:0] OFF_CTRL    = ADDR_BITS'(12'h000);
  localparam logic [ADDR_BITS-1:0] OFF_SET     = ADDR_BITS'(12'h004);
  localparam logic [ADDR_BITS-1:0] OFF_CLR     = ADDR_BITS'(12'h008);
  localparam logic [ADDR_BITS-1:0] OFF_TIMING  = ADDR_BITS'(12'h010);
  localparam logic [ADDR_BITS-1:0] OFF_DATA    = ADDR_BITS'(12'h020);
  localparam logic [ADDR_BITS-1:0] OFF_SNS_CTL = ADDR_BITS'(12'h030);
  localparam logic [ADDR_BITS-1:0] OFF_SNS_DAT = ADDR_BITS'(12'h040);

  // ---------------- reset synchronizer ----------------
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // ---------------- state ----------------
  logic [KEY_W-1:0]   unlock_q, unlock_d;
  logic [WADDR_W-1:0] waddr_q, waddr_d;
  logic               err_q, err_d;
  logic [RDSTB_W-1:0] trd_q, trd_d;
  logic [RELAX_W-1:0] trlx_q, trlx_d;
  logic [PGSTB_W-1:0] tpg_q, tpg_d;
  op_kind_e           op_q, op_d;
  logic [IDX_W-1:0]   oidx_q, oidx_d;
  logic [DATA_W-1:0]  odata_q, odata_d;
  logic [DATA_W-1:0]  sense_q, sense_d;

  logic busy, done;
  logic [DATA_W-1:0] fuse_rdata, sh_rdata;

  // ---------------- decode ----------------
  logic wr_ctrl, wr_set, wr_clr, wr_tim, prog_req, sense_req;
  logic addr_ok, key_ok, prog_go, sense_go, start, err_set;
  logic sh_region, sh_hit, sh_wr;
  logic [SIDX_W-1:0] sh_raw;
  logic [PGSTB_W-1:0] seq_strobe;

  assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_set    = bus_wr && (bus_addr == OFF_SET);
  assign wr_clr    = bus_wr && (bus_addr == OFF_CLR);
  assign wr_tim    = bus_wr && (bus_addr == OFF_TIMING);
  assign prog_req  = bus_wr && (bus_addr == OFF_DATA);
  assign sense_req = bus_wr && (bus_addr == OFF_SNS_CTL) && bus_wdata[0];

  assign addr_ok  = (32'(waddr_q) < NUM_WORDS);
  assign key_ok   = (unlock_q == UNLOCK_KEY);
  assign prog_go  = prog_req && !busy && key_ok && addr_ok;
  assign sense_go = sense_req && !busy && addr_ok;
  assign start    = prog_go || sense_go;
  assign err_set  = (prog_req && !prog_go) || (sense_req && !sense_go);

  assign sh_region = bus_addr[ADDR_BITS-1];
  assign sh_raw    = bus_addr[ADDR_BITS-2:2];
  assign sh_hit    = sh_region && (32'(sh_raw) < NUM_WORDS);
  assign sh_wr     = bus_wr && sh_hit;

  // ---------------- next state ----------------
  always_comb begin
    unlock_d = unlock_q;
    waddr_d  = waddr_q;
    err_d    = err_q;
    trd_d    = trd_q;
    trlx_d   = trlx_q;
    tpg_d    = tpg_q;
    op_d     = op_q;
    oidx_d   = oidx_q;
    odata_d  = odata_q;
    sense_d  = sense_q;

    if (done && (op_q == OP_PROG)) begin
      unlock_d = '0;
    end
    if (done && (op_q == OP_SENSE)) begin
      sense_d = fuse_rdata;
    end

    if (wr_ctrl) begin
      unlock_d = bus_wdata[31:16];
      waddr_d  = bus_wdata[WADDR_W-1:0];
    end else if (wr_set) begin
      unlock_d = unlock_q | bus_wdata[31:16];
      waddr_d  = waddr_q  | bus_wdata[WADDR_W-1:0];
    end else if (wr_clr) begin
      unlock_d = unlock_q & ~bus_wdata[31:16];
      waddr_d  = waddr_q  & ~bus_wdata[WADDR_W-1:0];
    end

    if (err_set) begin
      err_d = 1'b1;
    end else if (wr_clr && bus_wdata[CTRL_ERR_BIT]) begin
      err_d = 1'b0;
    end

    if (wr_tim) begin
      trd_d  = bus_wdata[21:16];
      trlx_d = bus_wdata[15:12];
      tpg_d  = bus_wdata[11:0];
    end

    if (start) begin
      op_d   = prog_go ? OP_PROG : OP_SENSE;
      oidx_d = waddr_q[IDX_W-1:0];
      if (prog_go) begin
        odata_d = bus_wdata;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      unlock_q <= '0;
      waddr_q  <= '0;
      err_q    <= 1'b0;
      trd_q    <= RDSTB_W'(RDSTB_RST);
      trlx_q   <= RELAX_W'(RELAX_RST);
      tpg_q    <= PGSTB_W'(PGSTB_RST);
      op_q     <= OP_SENSE;
      oidx_q   <= '0;
      odata_q  <= '0;
      sense_q  <= '0;
    end else begin
      unlock_q <= unlock_d;
      waddr_q  <= waddr_d;
      err_q    <= err_d;
      trd_q    <= trd_d;
      trlx_q   <= trlx_d;
      tpg_q    <= tpg_d;
      op_q     <= op_d;
      oidx_q   <= oidx_d;
      odata_q  <= odata_d;
      sense_q  <= sense_d;
    end
  end

  // ---------------- submodules ----------------
  assign seq_strobe = prog_go ? tpg_q : PGSTB_W'(trd_q);

  otp_seq #(
    .CNT_W (PGSTB_W),
    .RLX_W (RELAX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start      (start),
    .strobe_cnt (seq_strobe),
    .relax_cnt  (trlx_q),
    .busy       (busy),
    .done       (done)
  );

  otp_store #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .prog_en    (done && (op_q == OP_PROG)),
    .prog_idx   (oidx_q),
    .prog_data  (odata_q),
    .sh_wr      (sh_wr),
    .sh_idx     (sh_raw[IDX_W-1:0]),
    .sh_wdata   (bus_wdata),
    .fuse_idx   (oidx_q),
    .fuse_rdata (fuse_rdata),
    .sh_rdata   (sh_rdata)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (sh_hit) begin
      bus_rdata = sh_rdata;
    end else begin
      unique case (bus_addr)
        OFF_CTRL, OFF_SET, OFF_CLR:
          bus_rdata = {unlock_q, 6'b0, err_q, busy, 1'b0, waddr_q};
        OFF_TIMING:  bus_rdata = {10'b0, trd_q, trlx_q, tpg_q};
        OFF_SNS_DAT: bus_rdata = sense_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (err_q && !(wr_clr && bus_wdata[CTRL_ERR_BIT])) |=> err_q);

  p_unlock_wiped_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done && (op_q == OP_PROG) && !wr_ctrl && !wr_set) |=> (unlock_q == '0));

  p_prog_keyed_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($rose(busy) && (op_q == OP_PROG)) |-> ($past(unlock_q) == UNLOCK_KEY));

  p_nokey_errs_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (prog_req && (unlock_q != UNLOCK_KEY)) |=> (err_q && $stable(busy)));
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  localparam logic [9:0] A_CTRL = 10'h000, A_SET = 10'h004, A_CLR = 10'h008,
                         A_TIM  = 10'h010, A_DATA = 10'h020, A_SCTL = 10'h030,
                         A_SDAT = 10'h040, A_SH = 10'h200;
  localparam logic [31:0] KEY = 32'h3E77_0000;

  otp_fuse_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Called right after a starting write; returns clocks with busy high.
  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    rd(A_CTRL, v);
    while (v[8] && n < 10000) begin
      n++;
      @(negedge clk);
      rd(A_CTRL, v);
    end
  endtask

  task automatic sense(input logic [6:0] a, output logic [31:0] d);
    int n;
    wr(A_CTRL, {25'b0, a});
    wr(A_SCTL, 32'h1);
    busy_len(n);
    rd(A_SDAT, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    rd(A_TIM, v);  chk("R1 timing reset", v, 32'h0006_100A);
    rd(A_SDAT, v); chk("R1 sense reset", v, 32'h0);
    rd(A_SH + 10'd20, v); chk("R1 shadow reset", v, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl field layout", v, 32'hFFFF_007F);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl write zero", v, 32'h0);
  endtask

  task automatic t_aliases();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_0005);
    wr(A_SET, 32'h3E70_0002);
    rd(A_CTRL, v); chk("R3 set alias", v, 32'h3E70_0007);
    wr(A_CLR, 32'h0000_0001);
    rd(A_CTRL, v); chk("R3 clear alias", v, 32'h3E70_0006);
    wr(A_DATA, 32'h1);              // wrong key
    rd(A_CTRL, v); chk("R9 wrong key sets error", v, 32'h3E70_0206);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R3 error survives direct write", v, 32'h0000_0200);
    wr(A_CLR, 32'h0000_0200);
    rd(A_CTRL, v); chk("R3 error cleared by alias", v, 32'h0);
    rd(A_SH + 10'd24, v); chk("R9 wrong key no program", v, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(A_TIM, 32'hFFFF_FFFF);
    rd(A_TIM, v); chk("R4 timing layout", v, 32'h003F_FFFF);
    wr(A_TIM, (32'd8 << 16) | (32'd2 << 12) | 32'd20);
    rd(A_TIM, v); chk("R4 timing readback", v, 32'h0008_2014);
  endtask

  task automatic t_program();
    logic [31:0] v;
    int n;
    wr(A_CTRL, KEY | 32'd11);       // bank 1, word 3
    wr(A_DATA, 32'h0000_00F0);
    busy_len(n);
    chk("R5 program busy length", 32'(n), 32'd21);
    rd(A_SH + 10'h02C, v); chk("R11 shadow bank1 word3", v, 32'h0000_00F0);
    rd(A_CTRL, v); chk("R7 unlock wiped", v, 32'd11);
    wr(A_SET, KEY);
    wr(A_DATA, 32'h0F00_000F);
    busy_len(n);
    rd(A_SH + 10'h02C, v); chk("R6 program ORs bits", v, 32'h0F00_00FF);
    wr(A_CTRL, 32'd11);
    wr(A_SCTL, 32'h1);
    busy_len(n);
    chk("R5 sense busy length", 32'(n), 32'd9);
    rd(A_SDAT, v); chk("R8 sense result", v, 32'h0F00_00FF);
  endtask

  task automatic t_short_strobe();
    logic [31:0] v;
    int n;
    wr(A_TIM, (32'd1 << 16) | (32'd3 << 12) | 32'd0);
    wr(A_CTRL, 32'd11);
    wr(A_SCTL, 32'h1);
    busy_len(n);
    chk("R5 relax floor sense", 32'(n), 32'd9);
    wr(A_TIM, 32'h0);
    wr(A_CTRL, KEY | 32'd5);
    wr(A_DATA, 32'h8000_0000);
    busy_len(n);
    chk("R5 minimal program", 32'(n), 32'd3);
    rd(A_SH + 10'd20, v); chk("R6 short program result", v, 32'h8000_0000);
    wr(A_TIM, (32'd8 << 16) | (32'd2 << 12) | 32'd20);
  endtask

  task automatic t_sense_bit0();
    logic [31:0] v;
    wr(A_CTRL, 32'd5);
    wr(A_SCTL, 32'hFFFF_FFFE);
    rd(A_CTRL, v); chk("R8 bit0 clear starts nothing", v, 32'd5);
    rd(A_SDAT, v); chk("R8 sense data unchanged", v, 32'h0F00_00FF);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    int n;
    wr(A_CTRL, KEY | 32'd6);
    wr(A_SCTL, 32'h1);
    wr(A_SCTL, 32'h1);              // while busy
    rd(A_CTRL, v); chk("R9 sense while busy", v & 32'h0000_0200, 32'h0000_0200);
    wr(A_DATA, 32'h0000_FFFF);      // while busy, key present
    busy_len(n);
    chk("R9 busy run not extended", 32'(n), 32'd7);
    wr(A_CLR, 32'h0000_0200);
    sense(7'd6, v); chk("R9 busy program ignored", v, 32'h0);
    wr(A_CTRL, KEY | 32'd20);
    wr(A_DATA, 32'h1);
    rd(A_CTRL, v); chk("R9 address past array", v, KEY | 32'h0000_0214);
    wr(A_CLR, 32'h0000_0200);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    int n;
    wr(A_SH + 10'd8, 32'hDEAD_BEEF);
    rd(A_SH + 10'd8, v); chk("R10 shadow override", v, 32'hDEAD_BEEF);
    sense(7'd2, v); chk("R10 fuse untouched", v, 32'h0);
    wr(A_CTRL, KEY | 32'd2);
    wr(A_DATA, 32'h1);
    busy_len(n);
    rd(A_SH + 10'd8, v); chk("R6 shadow from fuse", v, 32'h1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0;
    bus_wr = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_aliases();
    t_timing();
    t_program();
    t_short_strobe();
    t_sense_bit0();
    t_errors();
    t_shadow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule